// File: doc/BRIEF.md
# FPU Error Signaling Controller

This block sits next to the status logic of a floating-point unit and implements the old style of exception reporting, in which errors leave the core on a pin that external logic routes to an interrupt line. Each exception event comes with six cause bits and a qualifier. The qualifier says whether the error pin should drop at once or only when the next waiting instruction arrives. The block keeps the sticky cause flags and the error-summary bit. It drives the active-low error pin, and it asks the pipeline to stall any waiting or packed-integer SIMD instruction while an unmasked error is pending.

Software clears the pending state with a clear-exceptions command. Non-waiting control instructions pass freely, so a handler can run with an error outstanding. While the active-low ignore input is held low, all error signaling is held back: no pin and no stall. The flags are still recorded.

Top module: `fpu_err_signal`

## Requirements
- R1: Each exception event ORs its cause bits into the sticky flags (`sticky_flags[i]` belongs to cause `i`), masked or not. The flags are visible from the cycle after the strobe and hold until a clear or a reset.
- R2: `err_summary` is high exactly when some sticky flag has its mask bit at 0 (a mask bit of 1 masks that cause). It follows a change of `ctrl_mask` in the same cycle.
- R3: Take an event with `exc_defer`=0, at least one unmasked cause and `err_ignore_n`=1. `err_pin_n` goes low in the cycle after the strobe.
- R4: Take an event with `exc_defer`=1. `err_pin_n` stays high until decode presents a waiting instruction, and it goes low in that same cycle.
- R5: With `err_summary` high and `err_ignore_n`=1, `stall_req` is high in any cycle where `dec_valid`=1 and `dec_kind` is 0 (WAIT), 1 (waiting FP op) or 2 (packed-integer SIMD). For `dec_kind`=3 (non-waiting control) it is never high.
- R6: Once `err_pin_n` is low, it stays low as a level until a clear or a reset, unless `err_ignore_n` is low.
- R7: An event whose causes are all masked sets only its flags. It raises no `err_summary`, no pin and no stall.
- R8: While `err_ignore_n`=0, `err_pin_n` is high and `stall_req` is low, but flags are still recorded.
- R9: After a cycle with `clr_exc`=1, the flags, `err_summary` and `stall_req` are 0 and `err_pin_n` is 1. An event in that same cycle is recorded on top of the cleared state.
- R10: Unmasking a flag that is already set raises `err_summary` at once. The pin stays high until the next waiting instruction.
- R11: A synchronous reset clears all flags and pin state and drives `err_pin_n` high and `stall_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_valid | input | 1 | Exception event strobe |
| exc_flags | input | NUM_EXC | Cause bits of the event |
| exc_defer | input | 1 | 1: defer pin assertion to the next waiting instruction |
| ctrl_mask | input | NUM_EXC | Mask bits, 1 = cause masked |
| err_ignore_n | input | 1 | Active-low ignore-error input |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_kind | input | 2 | 0 WAIT, 1 waiting FP, 2 packed SIMD, 3 non-waiting control |
| clr_exc | input | 1 | Clear-exceptions command |
| sticky_flags | output | NUM_EXC | Sticky cause flags |
| err_summary | output | 1 | Error-summary bit |
| err_pin_n | output | 1 | Active-low error level to the interrupt line |
| stall_req | output | 1 | Freeze request for the decoded instruction |

## Verification
The bench works through the orderings that are easy to get wrong:
- A masked event followed by an unmask. A design that asserted the pin when the mask changed would drop `err_pin_n` a cycle too early.
- A deferred event. A design that registered the freeze-time assertion would let the stalled instruction's first cycle pass with the pin still high.
- A control instruction presented with an error pending. A stalling design would deadlock the handler.
- A clear that coincides with a fresh event. A design that gave the clear blanket priority would lose that event.
- The ignore input over an already latched pin, and a reset in the middle of a pending error.

// File: rtl/fperr_pkg.sv
package fperr_pkg;

    typedef enum logic [1:0] {
        DK_WAIT   = 2'd0,
        DK_FPWAIT = 2'd1,
        DK_SIMD   = 2'd2,
        DK_CTRL   = 2'd3
    } dec_kind_e;

    typedef struct packed {
        logic valid;
        logic defer;
    } exc_qual_t;

    function automatic logic kind_waits(input dec_kind_e k);
        return (k == DK_WAIT) || (k == DK_FPWAIT) || (k == DK_SIMD);
    endfunction

endpackage

// File: rtl/fperr_flag_bank.sv
module fperr_flag_bank #(
    parameter int NUM_EXC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ev_valid,
    input  logic [NUM_EXC-1:0] ev_flags,
    input  logic [NUM_EXC-1:0] mask,
    input  logic               clr,
    output logic [NUM_EXC-1:0] flags,
    output logic               es,
    output logic               ev_unmasked
);
    logic [NUM_EXC-1:0] pending;

    for (genvar i = 0; i < NUM_EXC; i++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)
                bit_q <= 1'b0;
            else if (clr)
                bit_q <= ev_valid & ev_flags[i];
            else if (ev_valid & ev_flags[i])
                bit_q <= 1'b1;
        end
        assign flags[i]   = bit_q;
        assign pending[i] = bit_q & ~mask[i];
    end

    always_comb begin
        es          = |pending;
        ev_unmasked = ev_valid & (|(ev_flags & ~mask));
    end
endmodule

// File: rtl/fperr_freeze_ctl.sv
module fperr_freeze_ctl
    import fperr_pkg::*;
(
    input  logic      dec_valid,
    input  dec_kind_e dec_kind,
    input  logic      es,
    input  logic      ign_n,
    output logic      freeze
);
    always_comb begin
        freeze = dec_valid & kind_waits(dec_kind) & es & ign_n;
    end
endmodule

// File: rtl/fperr_pin_ctl.sv
module fperr_pin_ctl
    import fperr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      ign_n,
    input  exc_qual_t qual,
    input  logic      ev_unmasked,
    input  logic      freeze,
    output logic      pin_n
);
    logic pin_q;
    logic hit_now;

    always_comb begin
        hit_now = qual.valid & ~qual.defer & ev_unmasked & ign_n;
    end

    always_ff @(posedge clk) begin
        if (rst)
            pin_q <= 1'b0;
        else if (clr)
            pin_q <= hit_now;
        else if (hit_now | freeze)
            pin_q <= 1'b1;
    end

    always_comb begin
        pin_n = ~(ign_n & (pin_q | freeze));
    end
endmodule

// File: rtl/fpu_err_signal.sv
module fpu_err_signal
    import fperr_pkg::*;
#(
    parameter int NUM_EXC = 6
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               exc_valid,
    input  logic [NUM_EXC-1:0] exc_flags,
    input  logic               exc_defer,
    input  logic [NUM_EXC-1:0] ctrl_mask,
    input  logic               err_ignore_n,
    input  logic               dec_valid,
    input  logic [1:0]         dec_kind,
    input  logic               clr_exc,
    output logic [NUM_EXC-1:0] sticky_flags,
    output logic               err_summary,
    output logic               err_pin_n,
    output logic               stall_req
);
    exc_qual_t qual;
    dec_kind_e kind;
    logic      es;
    logic      ev_unmasked;
    logic      freeze;

    always_comb begin
        qual.valid = exc_valid;
        qual.defer = exc_defer;
        kind       = dec_kind_e'(dec_kind);
    end

    fperr_flag_bank #(.NUM_EXC(NUM_EXC)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .ev_valid    (exc_valid),
        .ev_flags    (exc_flags),
        .mask        (ctrl_mask),
        .clr         (clr_exc),
        .flags       (sticky_flags),
        .es          (es),
        .ev_unmasked (ev_unmasked)
    );

    fperr_freeze_ctl u_freeze (
        .dec_valid (dec_valid),
        .dec_kind  (kind),
        .es        (es),
        .ign_n     (err_ignore_n),
        .freeze    (freeze)
    );

    fperr_pin_ctl u_pin (
        .clk         (clk),
        .rst         (rst),
        .clr         (clr_exc),
        .ign_n       (err_ignore_n),
        .qual        (qual),
        .ev_unmasked (ev_unmasked),
        .freeze      (freeze),
        .pin_n       (err_pin_n)
    );

    assign err_summary = es;
    assign stall_req   = freeze;
endmodule

// File: rtl/fpu_err_signal_chk.sv
module fpu_err_signal_chk #(
    parameter int NUM_EXC = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               exc_valid,
    input logic [NUM_EXC-1:0] exc_flags,
    input logic               exc_defer,
    input logic [NUM_EXC-1:0] ctrl_mask,
    input logic               err_ignore_n,
    input logic               dec_valid,
    input logic [1:0]         dec_kind,
    input logic               clr_exc,
    input logic [NUM_EXC-1:0] sticky_flags,
    input logic               err_summary,
    input logic               err_pin_n,
    input logic               stall_req
);
    assert_sticky_R1: assert property (@(posedge clk) disable iff (rst)
        !clr_exc |=> ((sticky_flags & $past(sticky_flags)) == $past(sticky_flags)));

    assert_immediate_pin_R3: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !exc_defer && err_ignore_n && ((exc_flags & ~ctrl_mask) != '0))
        |=> (!err_ignore_n || !err_pin_n));

    assert_ctrl_never_stalls_R5: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_kind == 2'd3) |-> !stall_req);

    assert_stall_needs_es_R5: assert property (@(posedge clk) disable iff (rst)
        stall_req |-> err_summary);

    assert_stall_drives_pin_R4: assert property (@(posedge clk) disable iff (rst)
        stall_req |-> !err_pin_n);

    assert_pin_level_R6: assert property (@(posedge clk) disable iff (rst)
        (!err_pin_n && !clr_exc) |=> (!err_ignore_n || !err_pin_n));

    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (exc_valid && !clr_exc && !err_summary && ((exc_flags & ~ctrl_mask) == '0))
        |=> (!$stable(ctrl_mask) || !err_summary));

    assert_ignore_R8: assert property (@(posedge clk) disable iff (rst)
        !err_ignore_n |-> (err_pin_n && !stall_req));

    assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (clr_exc && !exc_valid) |=> (sticky_flags == '0 && !err_summary && err_pin_n && !stall_req));

    assert_reset_R11: assert property (@(posedge clk)
        rst |=> (sticky_flags == '0 && err_pin_n));
endmodule

bind fpu_err_signal fpu_err_signal_chk #(.NUM_EXC(NUM_EXC)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .exc_valid    (exc_valid),
    .exc_flags    (exc_flags),
    .exc_defer    (exc_defer),
    .ctrl_mask    (ctrl_mask),
    .err_ignore_n (err_ignore_n),
    .dec_valid    (dec_valid),
    .dec_kind     (dec_kind),
    .clr_exc      (clr_exc),
    .sticky_flags (sticky_flags),
    .err_summary  (err_summary),
    .err_pin_n    (err_pin_n),
    .stall_req    (stall_req)
);

// File: tb/fpu_err_signal_tb.sv
module fpu_err_signal_tb;
    localparam int N = 6;

    logic         clk = 1'b0;
    logic         rst;
    logic         exc_valid;
    logic [N-1:0] exc_flags;
    logic         exc_defer;
    logic [N-1:0] ctrl_mask;
    logic         err_ignore_n;
    logic         dec_valid;
    logic [1:0]   dec_kind;
    logic         clr_exc;
    logic [N-1:0] sticky_flags;
    logic         err_summary;
    logic         err_pin_n;
    logic         stall_req;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    fpu_err_signal #(.NUM_EXC(N)) u_dut (
        .clk(clk), .rst(rst), .exc_valid(exc_valid), .exc_flags(exc_flags),
        .exc_defer(exc_defer), .ctrl_mask(ctrl_mask), .err_ignore_n(err_ignore_n),
        .dec_valid(dec_valid), .dec_kind(dec_kind), .clr_exc(clr_exc),
        .sticky_flags(sticky_flags), .err_summary(err_summary),
        .err_pin_n(err_pin_n), .stall_req(stall_req)
    );

    // Stimulus, then expected outputs seen in the same cycle before its clock edge.
    typedef struct packed {
        logic       ev;
        logic [5:0] fl;
        logic       df;
        logic [5:0] mk;
        logic       ign_n;
        logic       dv;
        logic [1:0] dk;
        logic       clr;
        logic [5:0] xf;
        logic       xes;
        logic       xpin_n;
        logic       xst;
        logic [7:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 6'h00, 1'b0, 6'h3F, 1'b1, 1'b0, 2'd0, 1'b0, 6'h00, 1'b0, 1'b1, 1'b0, 8'd11}, // R11 idle
        '{1'b1, 6'h01, 1'b0, 6'h3F, 1'b1, 1'b0, 2'd0, 1'b0, 6'h00, 1'b0, 1'b1, 1'b0, 8'd7},  // R7 masked event
        '{1'b0, 6'h00, 1'b0, 6'h3F, 1'b1, 1'b1, 2'd1, 1'b0, 6'h01, 1'b0, 1'b1, 1'b0, 8'd7},  // R7 no stall
        '{1'b0, 6'h00, 1'b0, 6'h3E, 1'b1, 1'b0, 2'd0, 1'b0, 6'h01, 1'b1, 1'b1, 1'b0, 8'd10}, // R10 unmask
        '{1'b0, 6'h00, 1'b0, 6'h3E, 1'b1, 1'b1, 2'd3, 1'b0, 6'h01, 1'b1, 1'b1, 1'b0, 8'd5},  // R5 control
        '{1'b0, 6'h00, 1'b0, 6'h3E, 1'b1, 1'b1, 2'd2, 1'b0, 6'h01, 1'b1, 1'b0, 1'b1, 8'd10}, // R10 SIMD
        '{1'b0, 6'h00, 1'b0, 6'h3E, 1'b1, 1'b0, 2'd0, 1'b0, 6'h01, 1'b1, 1'b0, 1'b0, 8'd6},  // R6 hold
        '{1'b0, 6'h00, 1'b0, 6'h3E, 1'b1, 1'b0, 2'd0, 1'b1, 6'h01, 1'b1, 1'b0, 1'b0, 8'd9},  // R9 clear
        '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b0, 2'd0, 1'b0, 6'h00, 1'b0, 1'b1, 1'b0, 8'd9},  // R9 after
        '{1'b1, 6'h04, 1'b0, 6'h00, 1'b1, 1'b0, 2'd0, 1'b0, 6'h00, 1'b0, 1'b1, 1'b0, 8'd3},  // R3 event
        '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b0, 2'd0, 1'b0, 6'h04, 1'b1, 1'b0, 1'b0, 8'd3},  // R3 pin low
        '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b0, 2'd0, 1'b1, 6'h04, 1'b1, 1'b0, 1'b0, 8'd1},  // R1 clear
        '{1'b1, 6'h20, 1'b1, 6'h00, 1'b1, 1'b0, 2'd0, 1'b0, 6'h00, 1'b0, 1'b1, 1'b0, 8'd4},  // R4 deferred
        '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b0, 2'd0, 1'b0, 6'h20, 1'b1, 1'b1, 1'b0, 8'd4},  // R4 wait
        '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b1, 2'd0, 1'b0, 6'h20, 1'b1, 1'b0, 1'b1, 8'd4},  // R4 WAIT
        '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b1, 2'd1, 1'b0, 6'h20, 1'b1, 1'b0, 1'b1, 8'd5},  // R5 FP
        '{1'b0, 6'h00, 1'b0, 6'h00, 1'b0, 1'b1, 2'd1, 1'b0, 6'h20, 1'b1, 1'b1, 1'b0, 8'd8},  // R8 ignore
        '{1'b1, 6'h02, 1'b0, 6'h00, 1'b0, 1'b0, 2'd0, 1'b0, 6'h20, 1'b1, 1'b1, 1'b0, 8'd8},  // R8 event
        '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b0, 2'd0, 1'b0, 6'h22, 1'b1, 1'b0, 1'b0, 8'd1},  // R1 recorded
        '{1'b1, 6'h10, 1'b0, 6'h00, 1'b1, 1'b0, 2'd0, 1'b1, 6'h22, 1'b1, 1'b0, 1'b0, 8'd9},  // R9 clr+ev
        '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b0, 2'd0, 1'b0, 6'h10, 1'b1, 1'b0, 1'b0, 8'd9},  // R9 kept
        '{1'b0, 6'h00, 1'b0, 6'h00, 1'b1, 1'b0, 2'd0, 1'b1, 6'h10, 1'b1, 1'b0, 1'b0, 8'd9},  // R9 clear
        '{1'b0, 6'h00, 1'b0, 6'h3F, 1'b1, 1'b0, 2'd0, 1'b0, 6'h00, 1'b0, 1'b1, 1'b0, 8'd2}   // R2 empty
    };

    task automatic drive_idle();
        exc_valid = 1'b0; exc_flags = '0; exc_defer = 1'b0;
        dec_valid = 1'b0; dec_kind = 2'd0; clr_exc = 1'b0;
    endtask

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_all(input string tag, input logic [5:0] f, input logic e,
                           input logic p, input logic s);
        chk(tag, "flags", int'(sticky_flags), int'(f));
        chk(tag, "es",    int'(err_summary),  int'(e));
        chk(tag, "pin_n", int'(err_pin_n),    int'(p));
        chk(tag, "stall", int'(stall_req),    int'(s));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                checks++; errors++;
                $display("FAIL watchdog expired");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; ctrl_mask = '1; err_ignore_n = 1'b1;
        drive_idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1 chk_all("R11", 6'h00, 1'b0, 1'b1, 1'b0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            exc_valid = VECS[v].ev; exc_flags = VECS[v].fl; exc_defer = VECS[v].df;
            ctrl_mask = VECS[v].mk; err_ignore_n = VECS[v].ign_n;
            dec_valid = VECS[v].dv; dec_kind = VECS[v].dk; clr_exc = VECS[v].clr;
            #1 chk_all($sformatf("R%0d vec%0d", VECS[v].req, v),
                       VECS[v].xf, VECS[v].xes, VECS[v].xpin_n, VECS[v].xst);
        end

        // R2: mask change alone moves the summary bit within the cycle.
        @(negedge clk);
        drive_idle(); exc_valid = 1'b1; exc_flags = 6'h08; ctrl_mask = 6'h3F;
        @(negedge clk);
        drive_idle();
        #1 chk("R2", "es masked", int'(err_summary), 0);
        ctrl_mask = 6'h37;
        #1 chk("R2", "es unmasked", int'(err_summary), 1);
        chk("R10", "pin after unmask", int'(err_pin_n), 1);

        // R11: reset in the middle of a pending, latched error.
        dec_valid = 1'b1; dec_kind = 2'd0;
        #1 chk("R5", "stall on WAIT", int'(stall_req), 1);
        @(negedge clk);
        dec_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1 chk_all("R11", 6'h00, 1'b0, 1'b1, 1'b0);

        // R7: all-masked event with a waiting instruction right after.
        @(negedge clk);
        exc_valid = 1'b1; exc_flags = 6'h30; ctrl_mask = 6'h3F;
        @(negedge clk);
        drive_idle(); dec_valid = 1'b1; dec_kind = 2'd2;
        #1 chk_all("R7", 6'h30, 1'b0, 1'b1, 1'b0);

        @(negedge clk);
        drive_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule